// File: doc/BRIEF.md
# Victim Buffer for a Direct-Mapped Cache

This block is a small fully associative store that sits beside a direct-mapped primary cache, on the path that refills the cache. When a fill after a miss pushes a line out of the primary cache, the pushed-out line is offered to this buffer together with its line address and dirty flag. The buffer holds only such pushed-out lines. It never holds a line that came straight from memory.

After a primary miss, the cache controller presents the missing line address on the lookup port. Every entry's tag is compared against it in parallel, and a match returns the line and its dirty flag in the same cycle. If the controller offers the line it is displacing in that same cycle, the two lines trade places. The returned line goes back into the primary cache and the displaced line takes over the matching entry, so no memory access is needed.

When a line must be stored and no slot is free, the least recently used entry is replaced. If that entry is dirty, it is pushed out on the writeback port. The writeback is presented in the cycle after the replacement.

Top module: `victim_store`

## Requirements
- R1: When `rst_n` is sampled low at a clock edge, every entry is made invalid and `wb_valid` goes to 0. The age order is reset so that entry 0 is the oldest, then entries 1, 2 and 3 follow, with entry 3 the youngest.
- R2: With `lk_valid` high, all valid entries are compared with `lk_addr` in the same cycle. A match drives `lk_hit` high combinationally, with the stored line on `lk_data` and its dirty flag on `lk_dirty`. With `lk_valid` low, `lk_hit` is 0 whatever the address.
- R3: A lookup hit with `ins_valid` high in the same cycle is a swap. At the clock edge the matching entry takes `ins_addr`, `ins_data` and `ins_dirty`. Each dirty flag stays with its own line, and no writeback results.
- R4: A lookup hit with `ins_valid` low releases the matching entry at the clock edge, because the line has returned to the primary cache. A later lookup of that address misses.
- R5: An insert with no lookup hit, whose address is not held, goes into the lowest-numbered invalid entry if one exists. No writeback results.
- R6: When every entry is valid, an insert of an address not held replaces the least recently used entry. A swap and any insert make the written entry the most recently used.
- R7: When the replaced entry was dirty, `wb_valid` is high for exactly the one cycle after the replacing edge, with the old line on `wb_addr` and `wb_data`. Replacing a clean entry raises no writeback.
- R8: A lookup and an insert of the same address in one cycle count as a hit on the incoming line: `lk_data` and `lk_dirty` come from the insert port. The stored contents are left unchanged and no writeback results.
- R9: At most one entry matches any address. An insert of an address already held overwrites that entry in place, makes it the most recently used, and raises no writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request after a primary miss |
| lk_addr | input | ADDR_W | Line address searched for |
| lk_hit | output | 1 | A valid entry (or the same-cycle insert) matches |
| lk_data | output | WORD_W*WORDS | Line returned on a hit |
| lk_dirty | output | 1 | Dirty flag of the returned line |
| ins_valid | input | 1 | Line displaced from the primary cache is offered |
| ins_addr | input | ADDR_W | Line address of the displaced line |
| ins_data | input | WORD_W*WORDS | Data of the displaced line |
| ins_dirty | input | 1 | Displaced line is modified relative to memory |
| wb_valid | output | 1 | A dirty line left the buffer and must be written to memory |
| wb_addr | output | ADDR_W | Line address of the line being written back |
| wb_data | output | WORD_W*WORDS | Data of the line being written back |

## Verification
The bench checks that the age order rotates correctly. It does this by filling the buffer and then driving more inserts: a wrong order would evict a clean line where a dirty one was due, or the reverse, and this shows up as a missing or wrong writeback. A slot freed by a take-back must be refilled before the oldest valid entry is displaced. A design that ignored free slots would drop a live line, and a later lookup would show it missing. The same-address lookup-and-insert case and the in-place overwrite are both checked. A design that stored the forwarded line, or put a duplicate in a second slot, would hit on a later lookup or evict the wrong line. A reset in the middle of the run must leave every earlier line missing, and it must restore entry 0 as the first victim.

// File: rtl/vb_pkg.sv
// Shared types for the victim buffer.
// Assumes: used only by the victim_store hierarchy.
package vb_pkg;
    // What the buffer does with its storage at the next clock edge.
    typedef enum logic [1:0] {
        ACT_IDLE  = 2'd0,  // no storage change
        ACT_SWAP  = 2'd1,  // hit entry exchanged with the incoming line
        ACT_TAKE  = 2'd2,  // hit entry handed back and released
        ACT_WRITE = 2'd3   // incoming line stored (refresh, free slot or LRU slot)
    } vb_act_e;
endpackage

// File: rtl/vb_first.sv
// Priority finder: reports whether any bit of vec is set and the index of
// the lowest set bit.
// Assumes: N >= 1 and IW is wide enough to hold N-1.
module vb_first #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  vec,
    output logic          any,
    output logic [IW-1:0] idx
);
    // Scan from the top down so the lowest set bit is the one that remains.
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/vb_match.sv
// Parallel tag comparator: compares one key against every valid entry at once
// and encodes the matching slot.
// Assumes: at most one valid entry holds any given tag.
module vb_match #(
    parameter int ENTRIES = 4,
    parameter int ADDR_W  = 28,
    parameter int IW      = 2
) (
    input  logic [ENTRIES-1:0][ADDR_W-1:0] tags,
    input  logic [ENTRIES-1:0]             valid,
    input  logic [ADDR_W-1:0]              key,
    output logic [ENTRIES-1:0]             vec,
    output logic                           any,
    output logic [IW-1:0]                  idx
);
    // One comparator per entry.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign vec[g] = valid[g] && (tags[g] == key);
    end

    vb_first #(.N(ENTRIES), .IW(IW)) u_enc (
        .vec (vec),
        .any (any),
        .idx (idx)
    );
endmodule

// File: rtl/vb_lru.sv
// Age-rank replacement tracker: each entry holds a rank, 0 for the youngest
// and ENTRIES-1 for the oldest. The ranks always form a permutation.
// Assumes: touch_idx < ENTRIES; the reset is synchronous and active low.
module vb_lru #(
    parameter int ENTRIES = 4,
    parameter int IW      = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          touch,
    input  logic [IW-1:0] touch_idx,
    output logic [IW-1:0] oldest
);
    logic [ENTRIES-1:0][IW-1:0] age_q;
    logic [IW-1:0]              touched_age;

    assign touched_age = age_q[touch_idx];

    // Reset puts entry 0 oldest; a touch moves one entry to youngest and
    // ages every entry that was younger than it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) age_q[i] <= IW'(ENTRIES - 1 - i);
        end else if (touch) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (IW'(i) == touch_idx)          age_q[i] <= '0;
                else if (age_q[i] < touched_age)  age_q[i] <= age_q[i] + 1'b1;
            end
        end
    end

    // Find the entry holding the highest rank.
    always_comb begin
        oldest = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (age_q[i] == IW'(ENTRIES - 1)) oldest = IW'(i);
        end
    end
endmodule

// File: rtl/victim_store.sv
// Victim buffer: a fully associative store for lines displaced from a
// direct-mapped primary cache. A lookup hit returns the line in the same
// cycle. A same-cycle insert then swaps into the hit slot; without an insert
// the slot is released. Inserts fill a free slot first and otherwise replace
// the LRU entry. Dirty lines that are replaced leave on a registered
// writeback port one cycle later.
// Assumes: the controller only looks up after a primary miss and only inserts
// lines displaced by a fill.
module victim_store #(
    parameter int ADDR_W  = 28,
    parameter int WORD_W  = 32,
    parameter int WORDS   = 4,
    parameter int ENTRIES = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     lk_valid,
    input  logic [ADDR_W-1:0]        lk_addr,
    output logic                     lk_hit,
    output logic [WORD_W*WORDS-1:0]  lk_data,
    output logic                     lk_dirty,
    input  logic                     ins_valid,
    input  logic [ADDR_W-1:0]        ins_addr,
    input  logic [WORD_W*WORDS-1:0]  ins_data,
    input  logic                     ins_dirty,
    output logic                     wb_valid,
    output logic [ADDR_W-1:0]        wb_addr,
    output logic [WORD_W*WORDS-1:0]  wb_data
);
    import vb_pkg::*;

    localparam int LINE_W = WORD_W * WORDS;
    localparam int IW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0]             valid_q, dirty_q;
    logic [ENTRIES-1:0][ADDR_W-1:0] tag_q;
    logic [ENTRIES-1:0][LINE_W-1:0] data_q;

    logic [ENTRIES-1:0] lk_vec, in_vec, free_vec;
    logic               lk_any, in_any, free_any, fwd, wb_need;
    logic [IW-1:0]      lk_idx, in_idx, free_idx, oldest, slot;
    vb_act_e            act;

    vb_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .IW(IW)) u_lk_match (
        .tags(tag_q), .valid(valid_q), .key(lk_addr),
        .vec(lk_vec), .any(lk_any), .idx(lk_idx)
    );

    vb_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .IW(IW)) u_in_match (
        .tags(tag_q), .valid(valid_q), .key(ins_addr),
        .vec(in_vec), .any(in_any), .idx(in_idx)
    );

    assign free_vec = ~valid_q;

    vb_first #(.N(ENTRIES), .IW(IW)) u_free (
        .vec(free_vec), .any(free_any), .idx(free_idx)
    );

    vb_lru #(.ENTRIES(ENTRIES), .IW(IW)) u_lru (
        .clk(clk), .rst_n(rst_n),
        .touch(act == ACT_SWAP || act == ACT_WRITE),
        .touch_idx(slot), .oldest(oldest)
    );

    // Same-address lookup and insert forward the incoming line.
    assign fwd      = lk_valid && ins_valid && (lk_addr == ins_addr);
    assign lk_hit   = lk_valid && (fwd || lk_any);
    assign lk_data  = fwd ? ins_data  : data_q[lk_idx];
    assign lk_dirty = fwd ? ins_dirty : dirty_q[lk_idx];

    // Decide the storage action and the slot it applies to.
    always_comb begin
        act  = ACT_IDLE;
        slot = '0;
        if (fwd) begin
            act = ACT_IDLE;
        end else if (lk_valid && lk_any) begin
            act  = ins_valid ? ACT_SWAP : ACT_TAKE;
            slot = lk_idx;
        end else if (ins_valid) begin
            act  = ACT_WRITE;
            slot = in_any ? in_idx : (free_any ? free_idx : oldest);
        end
    end

    // A dirty line is pushed out only when a different line replaces it.
    assign wb_need = (act == ACT_WRITE) && !in_any && valid_q[slot] && dirty_q[slot];

    // Valid and dirty state per entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (act == ACT_SWAP || act == ACT_WRITE) begin
            valid_q[slot] <= 1'b1;
            dirty_q[slot] <= ins_dirty;
        end else if (act == ACT_TAKE) begin
            valid_q[slot] <= 1'b0;
        end
    end

    // Tag and data payload; qualified by valid_q, so no reset is needed.
    always_ff @(posedge clk) begin
        if (act == ACT_SWAP || act == ACT_WRITE) begin
            tag_q[slot]  <= ins_addr;
            data_q[slot] <= ins_data;
        end
    end

    // Registered writeback of the replaced dirty line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_valid <= 1'b0;
        end else begin
            wb_valid <= wb_need;
        end
        if (wb_need) begin
            wb_addr <= tag_q[slot];
            wb_data <= data_q[slot];
        end
    end
endmodule

// File: rtl/vb_checker.sv
// Property checker for victim_store, attached with bind below.
// Assumes: clocked with the design clock and the same synchronous reset.
module vb_checker #(
    parameter int ADDR_W  = 28,
    parameter int LINE_W  = 128,
    parameter int ENTRIES = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               lk_valid,
    input logic [ADDR_W-1:0]  lk_addr,
    input logic               lk_hit,
    input logic [LINE_W-1:0]  lk_data,
    input logic               ins_valid,
    input logic [ADDR_W-1:0]  ins_addr,
    input logic [LINE_W-1:0]  ins_data,
    input logic               wb_valid,
    input logic [ENTRIES-1:0] valid_q,
    input logic [ENTRIES-1:0] lk_vec,
    input logic [ENTRIES-1:0] in_vec
);
    // R1: the first cycle out of reset sees an empty buffer and no writeback.
    assert_reset_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (valid_q == '0) && !wb_valid);

    // R2: no hit is reported without a lookup request.
    assert_no_idle_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> !lk_hit);

    // R4: a take-back without insert frees exactly one slot.
    assert_take_frees_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && (lk_vec != '0) && !ins_valid) |=>
        ($countones(valid_q) == $countones($past(valid_q)) - 1));

    // R7: a writeback only follows an insert.
    assert_wb_after_insert_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> $past(ins_valid));

    // R8: same-address lookup and insert return the incoming line.
    assert_fwd_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && ins_valid && lk_addr == ins_addr) |-> (lk_hit && lk_data == ins_data));

    // R8: forwarding leaves the occupancy untouched.
    assert_fwd_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && ins_valid && lk_addr == ins_addr) |=> $stable(valid_q));

    // R9: no address is ever held twice.
    assert_single_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_vec) && $onehot0(in_vec));
endmodule

bind victim_store vb_checker #(
    .ADDR_W(ADDR_W), .LINE_W(WORD_W * WORDS), .ENTRIES(ENTRIES)
) u_vb_checker (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_addr(lk_addr),
    .lk_hit(lk_hit), .lk_data(lk_data), .ins_valid(ins_valid),
    .ins_addr(ins_addr), .ins_data(ins_data), .wb_valid(wb_valid),
    .valid_q(valid_q), .lk_vec(lk_vec), .in_vec(in_vec)
);

// File: tb/tb_victim_store.sv
// Self-checking bench for victim_store: a vector table walked by one loop,
// then directed reset and replacement-order tests.
module tb_victim_store;
    localparam int ADDR_W = 28;
    localparam int WORD_W = 32;
    localparam int WORDS  = 4;
    localparam int LINE_W = WORD_W * WORDS;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              lk_valid = 1'b0, ins_valid = 1'b0, ins_dirty = 1'b0;
    logic [ADDR_W-1:0] lk_addr = '0, ins_addr = '0;
    logic [LINE_W-1:0] ins_data = '0;
    logic              lk_hit, lk_dirty, wb_valid;
    logic [LINE_W-1:0] lk_data, wb_data;
    logic [ADDR_W-1:0] wb_addr;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;  // 250 MHz

    victim_store #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .WORDS(WORDS), .ENTRIES(4)) dut (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_hit(lk_hit),
        .lk_data(lk_data), .lk_dirty(lk_dirty),
        .ins_valid(ins_valid), .ins_addr(ins_addr), .ins_data(ins_data),
        .ins_dirty(ins_dirty),
        .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data)
    );

    // Line pattern derived from a seed: word k = {16'h0, seed, k}.
    function automatic logic [LINE_W-1:0] line_of(input logic [7:0] s);
        logic [LINE_W-1:0] l;
        for (int k = 0; k < WORDS; k++) l[k*WORD_W +: WORD_W] = {16'h0, s, 8'(k)};
        return l;
    endfunction

    task automatic check(input string req, input logic [LINE_W-1:0] act, input logic [LINE_W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    typedef struct packed {
        logic       lv;  logic [7:0] la;
        logic       iv;  logic [7:0] ia; logic [7:0] is; logic id;
        logic       eh;  logic [7:0] es; logic ed;
        logic       ew;  logic [7:0] ewa; logic [7:0] ews;
    } vec_t;

    localparam int NV = 22;
    // lv la iv ia seed dirty | exp hit seed dirty | exp wb addr seed
    localparam vec_t VT [NV] = '{
        '{1'b0, 8'd0,  1'b1, 8'd10, 8'd1,  1'b0, 1'b0, 8'd0,  1'b0, 1'b0, 8'd0,  8'd0},  // R5 fill e0
        '{1'b0, 8'd0,  1'b1, 8'd11, 8'd2,  1'b1, 1'b0, 8'd0,  1'b0, 1'b0, 8'd0,  8'd0},  // R5 fill e1
        '{1'b0, 8'd0,  1'b1, 8'd12, 8'd3,  1'b0, 1'b0, 8'd0,  1'b0, 1'b0, 8'd0,  8'd0},  // R5 fill e2
        '{1'b0, 8'd0,  1'b1, 8'd13, 8'd4,  1'b1, 1'b0, 8'd0,  1'b0, 1'b0, 8'd0,  8'd0},  // R5 fill e3
        '{1'b1, 8'd14, 1'b0, 8'd0,  8'd0,  1'b0, 1'b0, 8'd0,  1'b0, 1'b0, 8'd0,  8'd0},  // R2 miss
        '{1'b1, 8'd11, 1'b1, 8'd20, 8'd5,  1'b0, 1'b1, 8'd2,  1'b1, 1'b0, 8'd0,  8'd0},  // R3 swap
        '{1'b0, 8'd0,  1'b1, 8'd21, 8'd6,  1'b1, 1'b0, 8'd0,  1'b0, 1'b0, 8'd0,  8'd0},  // R6 evict 10 clean
        '{1'b0, 8'd0,  1'b1, 8'd22, 8'd7,  1'b0, 1'b0, 8'd0,  1'b0, 1'b0, 8'd0,  8'd0},  // R6 evict 12 clean
        '{1'b0, 8'd0,  1'b1, 8'd23, 8'd8,  1'b0, 1'b0, 8'd0,  1'b0, 1'b1, 8'd13, 8'd4},  // R7 evict 13 dirty
        '{1'b1, 8'd13, 1'b0, 8'd0,  8'd0,  1'b0, 1'b0, 8'd0,  1'b0, 1'b0, 8'd0,  8'd0},  // R7 gone
        '{1'b1, 8'd21, 1'b0, 8'd0,  8'd0,  1'b0, 1'b1, 8'd6,  1'b1, 1'b0, 8'd0,  8'd0},  // R4 take
        '{1'b0, 8'd0,  1'b1, 8'd24, 8'd9,  1'b1, 1'b0, 8'd0,  1'b0, 1'b0, 8'd0,  8'd0},  // R5 refill freed e0
        '{1'b1, 8'd25, 1'b1, 8'd25, 8'd10, 1'b1, 1'b1, 8'd10, 1'b1, 1'b0, 8'd0,  8'd0},  // R8 forward
        '{1'b1, 8'd25, 1'b0, 8'd0,  8'd0,  1'b0, 1'b0, 8'd0,  1'b0, 1'b0, 8'd0,  8'd0},  // R8 not stored
        '{1'b1, 8'd20, 1'b1, 8'd26, 8'd11, 1'b1, 1'b1, 8'd5,  1'b0, 1'b0, 8'd0,  8'd0},  // R3 swap clean out
        '{1'b0, 8'd0,  1'b1, 8'd27, 8'd12, 1'b0, 1'b0, 8'd0,  1'b0, 1'b0, 8'd0,  8'd0},  // R6 evict 22
        '{1'b0, 8'd0,  1'b1, 8'd28, 8'd13, 1'b0, 1'b0, 8'd0,  1'b0, 1'b0, 8'd0,  8'd0},  // R6 evict 23
        '{1'b0, 8'd0,  1'b1, 8'd27, 8'd14, 1'b1, 1'b0, 8'd0,  1'b0, 1'b0, 8'd0,  8'd0},  // R9 overwrite
        '{1'b0, 8'd0,  1'b1, 8'd29, 8'd15, 1'b0, 1'b0, 8'd0,  1'b0, 1'b1, 8'd24, 8'd9},  // R7 evict 24 dirty
        '{1'b0, 8'd26, 1'b0, 8'd0,  8'd0,  1'b0, 1'b0, 8'd0,  1'b0, 1'b0, 8'd0,  8'd0},  // R2 lk_valid low
        '{1'b1, 8'd26, 1'b0, 8'd0,  8'd0,  1'b0, 1'b1, 8'd11, 1'b1, 1'b0, 8'd0,  8'd0},  // R3 dirty travelled
        '{1'b1, 8'd27, 1'b0, 8'd0,  8'd0,  1'b0, 1'b1, 8'd14, 1'b1, 1'b0, 8'd0,  8'd0}   // R9 new content
    };

    // Drive one cycle at the falling edge; check the lookup before the rising
    // edge and the writeback just after it.
    task automatic step(input string req, input vec_t v);
        @(negedge clk);
        lk_valid  = v.lv;  lk_addr  = ADDR_W'(v.la);
        ins_valid = v.iv;  ins_addr = ADDR_W'(v.ia);
        ins_data  = line_of(v.is); ins_dirty = v.id;
        #1;
        check({req, " lk_hit"}, LINE_W'(lk_hit), LINE_W'(v.eh));
        if (v.eh) begin
            check({req, " lk_data"},  lk_data, line_of(v.es));
            check({req, " lk_dirty"}, LINE_W'(lk_dirty), LINE_W'(v.ed));
        end
        @(posedge clk); #1;
        check({req, " wb_valid"}, LINE_W'(wb_valid), LINE_W'(v.ew));
        if (v.ew) begin
            check({req, " wb_addr"}, LINE_W'(wb_addr), LINE_W'(v.ewa));
            check({req, " wb_data"}, wb_data, line_of(v.ews));
        end
    endtask

    function automatic vec_t ins_only(input logic [7:0] a, input logic [7:0] s, input logic d,
                                      input logic ew, input logic [7:0] ewa, input logic [7:0] ews);
        return '{1'b0, 8'd0, 1'b1, a, s, d, 1'b0, 8'd0, 1'b0, ew, ewa, ews};
    endfunction

    function automatic vec_t look_only(input logic [7:0] a, input logic eh, input logic [7:0] es, input logic ed);
        return '{1'b1, a, 1'b0, 8'd0, 8'd0, 1'b0, eh, es, ed, 1'b0, 8'd0, 8'd0};
    endfunction

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset wb_valid", LINE_W'(wb_valid), '0);
        @(negedge clk); rst_n = 1'b1;
        step("R1 empty lookup", look_only(8'd10, 1'b0, 8'd0, 1'b0));

        for (int i = 0; i < NV; i++) step($sformatf("vec%0d", i), VT[i]);

        // R1: reset in mid-run empties the buffer (28 was held in entry 3).
        @(negedge clk); rst_n = 1'b0; lk_valid = 1'b0; ins_valid = 1'b0;
        @(posedge clk); #1;
        check("R1 mid reset wb_valid", LINE_W'(wb_valid), '0);
        @(negedge clk); rst_n = 1'b1;
        step("R1 line lost after reset", look_only(8'd28, 1'b0, 8'd0, 1'b0));

        // R1/R6: after reset entry 0 is the first victim once full.
        step("R6 fill a", ins_only(8'd40, 8'd40, 1'b1, 1'b0, 8'd0, 8'd0));
        step("R6 fill b", ins_only(8'd41, 8'd41, 1'b0, 1'b0, 8'd0, 8'd0));
        step("R6 fill c", ins_only(8'd42, 8'd42, 1'b0, 1'b0, 8'd0, 8'd0));
        step("R6 fill d", ins_only(8'd43, 8'd43, 1'b1, 1'b0, 8'd0, 8'd0));
        step("R1 oldest is entry0", ins_only(8'd44, 8'd44, 1'b0, 1'b1, 8'd40, 8'd40));
        step("R7 wb pulse ends", ins_only(8'd45, 8'd45, 1'b0, 1'b0, 8'd0, 8'd0));
        step("R2 held line", look_only(8'd43, 1'b1, 8'd43, 1'b1));

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule